// File: doc/BRIEF.md
# Quadrature encoder up/down counter

This block keeps a position count between zero and a programmable ceiling. It can count the cycles of its own clock, or it can decode the two phase signals of an incremental encoder into up and down steps. The two encoder inputs must already be synchronous to the block clock. A small register port sets the counting mode, the ceiling, the clock divider and the enable. The same port reads the live count, the direction of the last step and a sticky update flag. The flag rises whenever the count wraps in either direction.

The counting mode and the divider value are double-buffered. A write to either register goes into a holding copy. The copy becomes active only when software issues an update request or when the count wraps. This lets software change the mode and the divider without stopping the counter. The count, direction and flag also appear as registered output pins for logic nearby.

Top module: `qenc_counter`

## Requirements
- R1: After synchronous reset the count, direction and update flag are 0. The enable, mode and divider registers read 0, and the ceiling reads all ones.
- R2: The mode field is MODE[2:0]. Value 0 is clock counting, 1 counts channel A edges, 2 counts channel B edges and 3 counts every edge. Values 4 to 7 are invalid, and with one of them active the count never changes.
- R3: Counting happens only while CTRL bit 0 (enable) is 1. In mode 0 the count rises by one on every clock cycle.
- R4: In mode 1, both edges of A step the count. The step is up when the new level of A differs from B, and down otherwise. Edges of B alone never step.
- R5: In mode 2, both edges of B step the count. The step is up when the new level of B equals A, and down otherwise. Edges of A alone never step.
- R6: In mode 3, a change on exactly one channel steps the count, using the rule from R4 for A and the rule from R5 for B. A cycle in which both channels change at once is ignored. In the state order {B,A}, the sequence 00, 01, 11, 10 counts up.
- R7: With divider value P active (the PSC register), the count moves once for every P+1 qualifying events.
- R8: An up step taken at or above the ceiling sets the count to 0. A down step taken at 0 sets the count to the ceiling. Either wrap sets the update flag, which is STATUS bit 0.
- R9: Writing STATUS with bit 0 equal to 0 clears the flag. Writing it with bit 0 equal to 1 leaves the flag unchanged.
- R10: The direction bit (CTRL bit 1 when read, and the pin dir_o) is 1 after a down step and 0 after an up step. It holds its value while no step occurs.
- R11: Writes to MODE and PSC take effect only after an update request or a wrap. An update request is a write to CTRL with bit 2 set. It also restarts the divider.
- R12: A write to COUNT loads the count directly and takes priority over a step in the same cycle. A write to CEIL takes effect at once.
- R13: The register addresses are CTRL=0, MODE=1, COUNT=2, CEIL=3, PSC=4 and STATUS=5; any other address reads 0. Read data appears one cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_i | input | 1 | Encoder channel A, synchronous |
| enc_b_i | input | 1 | Encoder channel B, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Registered read data |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction of the last step (1 = down) |
| update_flag_o | output | 1 | Sticky wrap flag |

## Verification
The bench drives every pair of start and end states on the two channels, in all seven non-clock modes. It computes the expected step from the Gray-order rules, so a decoder with one rule inverted counts backward and one that counts a simultaneous change on both channels drifts. The divider is swept over every value of a 4-bit field. A design that divides by P instead of P+1, or that applies a new divider before an update, ends with the wrong count. The wrap tests start from the ceiling, from zero, from above the ceiling and with a ceiling of 0. They catch a wrap that goes to the wrong end, a flag that a write of 1 clears, and a mode held in the holding copy that is never loaded on a wrap.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] QM_INC = 3'd0;
  localparam logic [MODE_W-1:0] QM_X2A = 3'd1;
  localparam logic [MODE_W-1:0] QM_X2B = 3'd2;
  localparam logic [MODE_W-1:0] QM_X4  = 3'd3;

  localparam int REG_CTRL   = 0;
  localparam int REG_MODE   = 1;
  localparam int REG_COUNT  = 2;
  localparam int REG_CEIL   = 3;
  localparam int REG_PSC    = 4;
  localparam int REG_STATUS = 5;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_DIR_BIT = 1;
  localparam int CTRL_UG_BIT  = 2;
  localparam int STAT_UPD_BIT = 0;
endpackage

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  output logic              step_o,
  output logic              up_o
);
  logic a_q, b_q;
  logic a_chg, b_chg, a_up, b_up;

  // Previous levels simply track the inputs; during reset they load the
  // current level so release never produces a false edge.
  always_ff @(posedge clk) begin
    a_q <= enc_a_i;
    b_q <= enc_b_i;
  end

  always_comb begin
    a_chg  = a_q ^ enc_a_i;
    b_chg  = b_q ^ enc_b_i;
    a_up   = enc_a_i ^ enc_b_i;
    b_up   = ~(enc_a_i ^ enc_b_i);
    step_o = 1'b0;
    up_o   = 1'b1;
    case (mode_i)
      QM_INC: begin
        step_o = en_i;
        up_o   = 1'b1;
      end
      QM_X2A: begin
        step_o = en_i & a_chg & ~b_chg;
        up_o   = a_up;
      end
      QM_X2B: begin
        step_o = en_i & b_chg & ~a_chg;
        up_o   = b_up;
      end
      QM_X4: begin
        step_o = en_i & (a_chg ^ b_chg);
        up_o   = a_chg ? a_up : b_up;
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b1;
      end
    endcase
  end

  assert_invalid_mode_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_i > QM_X4) |-> !step_o);

  assert_x2a_ignores_b_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == QM_X2A && a_q == enc_a_i) |-> !step_o);

  assert_x2b_ignores_a_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == QM_X2B && b_q == enc_b_i) |-> !step_o);

  assert_x4_double_change_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == QM_X4 && a_q != enc_a_i && b_q != enc_b_i) |-> !step_o);
endmodule

// File: rtl/qenc_prescale.sv
module qenc_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;
  logic             hit;

  // ">=" keeps the divider bounded if a smaller value becomes active mid-run.
  assign hit    = (div_q >= psc_i);
  assign tick_o = tick_i & hit;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      div_q <= '0;
    end else if (tick_i) begin
      div_q <= hit ? '0 : div_q + PSC_W'(1);
    end
  end

  assert_div_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !tick_o && !clr_i) |=> (div_q != '0));

  assert_idle_div_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(div_q));
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             flag_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             dir_q, flag_q;
  logic             at_top, at_bot, wrap;

  always_comb begin
    at_top  = (count_q >= ceil_i);
    at_bot  = (count_q == '0);
    wrap    = step_i && !cnt_we_i && (up_i ? at_top : at_bot);
    count_d = count_q;
    if (cnt_we_i) begin
      count_d = cnt_wd_i;
    end else if (step_i) begin
      if (up_i) count_d = at_top ? '0 : count_q + CNT_W'(1);
      else      count_d = at_bot ? ceil_i : count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      dir_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      if (step_i) dir_q <= ~up_i;
      if (wrap)            flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign dir_o   = dir_q;
  assign flag_o  = flag_q;
  assign wrap_o  = wrap;

  assert_up_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && up_i && !cnt_we_i && count_q >= ceil_i) |=> (count_q == '0));

  assert_down_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && !up_i && !cnt_we_i && count_q == '0) |=> (count_q == $past(ceil_i)));

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && up_i && !cnt_we_i && count_q >= ceil_i) |=> flag_q);

  assert_dir_follows_step_R10: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (dir_q == !$past(up_i)));

  assert_hold_no_step_R12: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !cnt_we_i) |=> $stable(count_q));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic              update_flag_o
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] A_CEIL   = ADDR_W'(REG_CEIL);
  localparam logic [ADDR_W-1:0] A_PSC    = ADDR_W'(REG_PSC);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

  logic              en_q;
  logic [MODE_W-1:0] mode_pre_q, mode_act_q;
  logic [PSC_W-1:0]  psc_pre_q, psc_act_q;
  logic [CNT_W-1:0]  ceil_q;
  logic [DATA_W-1:0] rd_q, rd_mux;

  logic wr_ctrl, wr_mode, wr_count, wr_ceil, wr_psc, wr_status;
  logic ug, load, flag_clr;
  logic raw_step, raw_up, step;
  logic wrap;
  logic [CNT_W-1:0] count;
  logic dir, flag;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_mode   = wr_en_i && (wr_addr_i == A_MODE);
  assign wr_count  = wr_en_i && (wr_addr_i == A_COUNT);
  assign wr_ceil   = wr_en_i && (wr_addr_i == A_CEIL);
  assign wr_psc    = wr_en_i && (wr_addr_i == A_PSC);
  assign wr_status = wr_en_i && (wr_addr_i == A_STATUS);

  assign ug       = wr_ctrl && wr_data_i[CTRL_UG_BIT];
  assign load     = ug || wrap;
  assign flag_clr = wr_status && !wr_data_i[STAT_UPD_BIT];

  qenc_decode u_decode (
    .clk     (clk),
    .rst     (rst),
    .enc_a_i (enc_a_i),
    .enc_b_i (enc_b_i),
    .mode_i  (mode_act_q),
    .en_i    (en_q),
    .step_o  (raw_step),
    .up_o    (raw_up)
  );

  qenc_prescale #(.PSC_W(PSC_W)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (ug),
    .tick_i (raw_step),
    .psc_i  (psc_act_q),
    .tick_o (step)
  );

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .up_i       (raw_up),
    .ceil_i     (ceil_q),
    .cnt_we_i   (wr_count),
    .cnt_wd_i   (wr_data_i[CNT_W-1:0]),
    .flag_clr_i (flag_clr),
    .count_o    (count),
    .dir_o      (dir),
    .flag_o     (flag),
    .wrap_o     (wrap)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_mux[CTRL_EN_BIT]  = en_q;
        rd_mux[CTRL_DIR_BIT] = dir;
      end
      A_MODE:   rd_mux[MODE_W-1:0] = mode_pre_q;
      A_COUNT:  rd_mux[CNT_W-1:0]  = count;
      A_CEIL:   rd_mux[CNT_W-1:0]  = ceil_q;
      A_PSC:    rd_mux[PSC_W-1:0]  = psc_pre_q;
      A_STATUS: rd_mux[STAT_UPD_BIT] = flag;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      mode_pre_q <= QM_INC;
      mode_act_q <= QM_INC;
      psc_pre_q  <= '0;
      psc_act_q  <= '0;
      ceil_q     <= '1;
      rd_q       <= '0;
    end else begin
      if (wr_ctrl) en_q       <= wr_data_i[CTRL_EN_BIT];
      if (wr_mode) mode_pre_q <= wr_data_i[MODE_W-1:0];
      if (wr_psc)  psc_pre_q  <= wr_data_i[PSC_W-1:0];
      if (wr_ceil) ceil_q     <= wr_data_i[CNT_W-1:0];
      if (load) begin
        mode_act_q <= mode_pre_q;
        psc_act_q  <= psc_pre_q;
      end
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  assign rd_data_o     = rd_q;
  assign count_o       = count;
  assign dir_o         = dir;
  assign update_flag_o = flag;

  assert_status_one_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_status && wr_data_i[STAT_UPD_BIT] && update_flag_o) |=> update_flag_o);

  assert_status_zero_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !wrap) |=> !update_flag_o);

  assert_update_loads_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (mode_act_q == $past(mode_pre_q) && psc_act_q == $past(psc_pre_q)));

  assert_no_update_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(mode_act_q) && $stable(psc_act_q)));

  assert_count_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> (count_o == $past(wr_data_i[CNT_W-1:0])));
endmodule

// File: tb/tb_qenc_counter.sv
`timescale 1ns/1ps
module tb_qenc_counter;
  localparam int CNT_W = 8, PSC_W = 4, DATA_W = 16, ADDR_W = 3;
  localparam int CEIL_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  count;
  logic dir, flag;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] cur = 2'b00;   // {B,A}

  always #4 clk = ~clk;

  qenc_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .count_o(count), .dir_o(dir), .update_flag_o(flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output int val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ADDR_W'(addr);
    @(negedge clk);
    val = int'(rd_data);
    rd_en = 1'b0;
  endtask

  task automatic drive(input logic [1:0] s);
    @(negedge clk);
    enc_b = s[1]; enc_a = s[0];
    @(negedge clk);
    cur = s;
  endtask

  function automatic logic [1:0] gray_up(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] gray_dn(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  // Expected step from R4/R5/R6: +1, -1 or 0. States are {B,A}.
  function automatic int delta(input int m, input logic [1:0] o, input logic [1:0] n);
    logic da, db;
    da = o[0] ^ n[0];
    db = o[1] ^ n[1];
    if (da && db) return 0;
    if ((m == 1 || m == 3) && da) return (n[0] != n[1]) ? 1 : -1;
    if ((m == 2 || m == 3) && db) return (n[1] == n[0]) ? 1 : -1;
    return 0;
  endfunction

  task automatic step_enc(input bit up);
    drive(up ? gray_up(cur) : gray_dn(cur));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, c, expc, edir, d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dir), 0);
    chk("R1 flag", int'(flag), 0);
    rd(0, v); chk("R1 CTRL", v, 0);
    rd(1, v); chk("R1 MODE", v, 0);
    rd(2, v); chk("R1 COUNT", v, 0);
    rd(3, v); chk("R1 CEIL", v, CEIL_MAX);
    rd(4, v); chk("R1 PSC", v, 0);
    rd(5, v); chk("R1 STATUS", v, 0);
    rd(6, v); chk("R13 unmapped", v, 0);

    // R3 clock counting while enabled
    wr(1, 1);
    rd(1, v); chk("R13 MODE readback", v, 1);
    wr(1, 0);
    wr(0, 1);
    repeat (10) @(negedge clk);
    chk("R3 ten cycles", int'(count), 10);
    wr(0, 0);
    c = int'(count);
    repeat (5) @(negedge clk);
    chk("R3 disabled hold", int'(count), c);
    rd(0, v); chk("R13 CTRL en clear", v & 1, 0);

    // R7 divider sweep in clock mode
    for (int p = 0; p < (1 << PSC_W); p++) begin
      wr(0, 0);
      wr(2, 0);
      wr(4, p);
      wr(0, 5);
      repeat (3 * (p + 1)) @(negedge clk);
      chk($sformatf("R7 psc=%0d", p), int'(count), 3);
    end

    // R11 divider write without update is held back
    wr(0, 0); wr(4, 0); wr(2, 0); wr(0, 5);
    wr(4, 3);
    c = int'(count);
    repeat (4) @(negedge clk);
    chk("R11 psc held", int'(count), (c + 4) % (CEIL_MAX + 1));
    wr(0, 5);
    c = int'(count);
    repeat (8) @(negedge clk);
    chk("R11 psc after update", int'(count), (c + 2) % (CEIL_MAX + 1));
    rd(4, v); chk("R13 PSC readback", v, 3);

    // R8 + R11: wrap loads the held mode (1), which then stops clock counting
    wr(0, 0); wr(4, 0); wr(1, 0); wr(0, 4);
    wr(5, 0);
    wr(3, 3);
    wr(2, 0);
    wr(1, 1);
    wr(0, 1);
    repeat (12) @(negedge clk);
    chk("R11 mode loaded on wrap", int'(count), 0);
    chk("R8 flag on wrap", int'(flag), 1);
    chk("R10 dir after up", int'(dir), 0);
    wr(0, 0);
    wr(3, CEIL_MAX);

    // R2 R4 R5 R6 exhaustive transition sweep
    for (int m = 1; m < 8; m++) begin
      wr(0, 0); wr(1, m); wr(2, 128); wr(0, 5);
      expc = 128;
      edir = int'(dir);
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 4; t++) begin
          d = delta(m, cur, 2'(s));
          expc = expc + d;
          if (d != 0) edir = (d < 0) ? 1 : 0;
          drive(2'(s));
          d = delta(m, cur, 2'(t));
          expc = expc + d;
          if (d != 0) edir = (d < 0) ? 1 : 0;
          drive(2'(t));
          chk($sformatf("R2/R4/R5/R6 mode=%0d %0d->%0d count", m, s, t), int'(count), expc);
          chk($sformatf("R10 mode=%0d %0d->%0d dir", m, s, t), int'(dir), edir);
        end
      end
    end

    // R7 divider on encoder edges
    wr(0, 0); wr(1, 3); wr(4, 1); wr(2, 128); wr(0, 5);
    repeat (4) step_enc(1'b1);
    chk("R7 x4 psc=1 up", int'(count), 130);
    repeat (2) step_enc(1'b0);
    chk("R7 x4 psc=1 down", int'(count), 129);
    chk("R10 dir down", int'(dir), 1);

    // R8 R9 wraps and flag handling in 4x mode
    wr(0, 0); wr(4, 0); wr(3, 5); wr(2, 5); wr(0, 5);
    wr(5, 0);
    chk("R9 clear by zero", int'(flag), 0);
    step_enc(1'b1);
    chk("R8 up wrap count", int'(count), 0);
    chk("R8 up wrap flag", int'(flag), 1);
    chk("R10 dir up", int'(dir), 0);
    wr(5, 1);
    chk("R9 write one keeps", int'(flag), 1);
    wr(5, 0);
    chk("R9 write zero clears", int'(flag), 0);
    step_enc(1'b0);
    chk("R8 down wrap count", int'(count), 5);
    chk("R8 down wrap flag", int'(flag), 1);
    rd(0, v); chk("R10 CTRL dir bit", v, 3);
    wr(2, 9);
    rd(2, v); chk("R12 COUNT readback", v, 9);
    step_enc(1'b1);
    chk("R8 above ceiling", int'(count), 0);
    wr(3, 0);
    rd(3, v); chk("R12 CEIL readback", v, 0);
    wr(5, 0);
    step_enc(1'b1);
    chk("R8 ceiling zero up", int'(count), 0);
    chk("R8 ceiling zero flag", int'(flag), 1);
    step_enc(1'b0);
    chk("R8 ceiling zero down", int'(count), 0);

    // R3 encoder edges ignored when disabled
    wr(3, CEIL_MAX); wr(2, 40); wr(0, 0);
    step_enc(1'b1);
    step_enc(1'b1);
    chk("R3 encoder disabled", int'(count), 40);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule